// File: doc/BRIEF.md
# Input Edge Rate Counter Bank

The block keeps one 32-bit rate register for each of a parameterised number of asynchronous input channels. Every channel is brought into the clock domain through a two-stage synchroniser. A rising transition of the synchronised signal advances a 31-bit wrapping counter. The top bit of the same register shows the channel's present synchronised level. Comparing that bit against the expected idle level is a quick way to confirm that the input polarity is configured correctly.

Software or a bus master reads the registers through a small read-only port. The registers sit in a fixed window of 65 addresses starting at 0xC000, with one address per implemented channel and channel 0 at the base. Each strobe into the window gets exactly one response on the next cycle. An implemented channel answers with an acknowledge and the register value. An address in the window with no channel behind it answers with an unknown-address flag. Addresses outside the window are left unanswered so that other blocks on the fabric can claim them.

The count field and the level bit of a register are updated on the same clock edge, and a read captures both in the same cycle. A value read while an edge is arriving is therefore never half old and half new.

Top module: `rate_bank`

## Requirements
- R1: After reset every counter reads as zero, and with all inputs low every register reads 0x00000000.
- R2: Bits DATA_W-2..0 of a register count rising edges of the synchronised input of that channel, one increment per 0-to-1 transition. Falling edges leave the count unchanged.
- R3: Bit DATA_W-1 (bit 31 by default) of a register is 1 while the synchronised input is high and 0 while it is low.
- R4: The counter wraps from its maximum value (all ones) to zero on the next rising edge and does not saturate.
- R5: A strobe with address 0xC000+i, where i < NUM_CH, gives ack_o high for exactly the next cycle, with rdata_o holding the register of channel i.
- R6: A strobe with an address from 0xC000+NUM_CH up to and including 0xC040 gives unk_o high for the next cycle, leaves ack_o low and drives rdata_o to zero.
- R7: A strobe with an address below 0xC000 or above 0xC040 raises neither ack_o nor unk_o.
- R8: ack_o and unk_o are never high together, and neither is high in a cycle that does not follow a strobe.
- R9: An edge on one channel leaves the registers of all other channels unchanged.
- R10: The count and level bits returned by one read come from the same clock cycle. While the input of a channel is rising, a read returns either the old count with level 0 or the new count with level 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ch_i | input | NUM_CH | Asynchronous channel inputs |
| addr_i | input | ADDR_W | Read address |
| rd_i | input | 1 | Read strobe, one cycle per read |
| rdata_o | output | DATA_W | Read data, valid with ack_o |
| ack_o | output | 1 | Read acknowledge, one cycle after the strobe |
| unk_o | output | 1 | Unknown address in the window, one cycle after the strobe |

## Verification
Single and repeated pulses on different channels separate a correct per-channel count from a miscount and from a lost or spurious increment. Reading an untouched channel alongside them shows whether edges cross between channels. A level held high and then dropped tells the live level bit apart from the count, and shows that falling edges are ignored. Back-to-back reads taken across a rising edge are accepted only as the pair (old count, level 0) or (new count, level 1), which catches a mixed capture. A narrow-counter instance is driven past its maximum to show wrapping rather than saturation. Reads at the window edges, in the unimplemented gap and just outside the window tell acknowledge, unknown-address and silence apart.

// File: rtl/rate_bank_pkg.sv
package rate_bank_pkg;
  localparam logic [15:0] RATE_BASE = 16'hC000;
  localparam logic [15:0] RATE_LAST = 16'hC040;

  typedef enum logic [1:0] {
    HIT_NONE = 2'd0,
    HIT_REG  = 2'd1,
    HIT_GAP  = 2'd2
  } hit_e;
endpackage

// File: rtl/rate_sync.sv
module rate_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] st_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= {st_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/rate_chan.sv
module rate_chan #(
  parameter int CNT_W  = 31,
  parameter int SYNC_N = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_i,
  output logic             lvl_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             sync_s;
  logic             lvl_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rise_s;

  rate_sync #(.STAGES(SYNC_N)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (in_i),
    .q_o   (sync_s)
  );

  assign rise_s = sync_s & ~lvl_q;

  // level and count advance on the same edge so a read sees them coherent
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      lvl_q <= sync_s;
      if (rise_s) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign lvl_o = lvl_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/rate_rd.sv
module rate_rd
  import rate_bank_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  localparam int CNT_W = DATA_W - 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_CH-1:0]              lvl_i,
  input  logic [NUM_CH-1:0][CNT_W-1:0]   cnt_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic                           rd_i,
  output logic [DATA_W-1:0]              rdata_o,
  output logic                           ack_o,
  output logic                           unk_o
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(RATE_BASE);
  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(RATE_LAST);

  hit_e              hit_s;
  logic [DATA_W-1:0] sel_s;
  logic [DATA_W-1:0] rdata_q;
  logic              ack_q;
  logic              unk_q;

  always_comb begin
    hit_s = HIT_NONE;
    sel_s = '0;
    if (rd_i && addr_i >= BASE_A && addr_i <= LAST_A) begin
      hit_s = HIT_GAP;
      for (int i = 0; i < NUM_CH; i++) begin
        if (addr_i == BASE_A + ADDR_W'(i)) begin
          hit_s = HIT_REG;
          sel_s = {lvl_i[i], cnt_i[i]};
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      ack_q   <= 1'b0;
      unk_q   <= 1'b0;
    end else begin
      ack_q   <= (hit_s == HIT_REG);
      unk_q   <= (hit_s == HIT_GAP);
      rdata_q <= (hit_s == HIT_REG) ? sel_s : '0;
    end
  end

  assign rdata_o = rdata_q;
  assign ack_o   = ack_q;
  assign unk_o   = unk_q;
endmodule

// File: rtl/rate_bank.sv
module rate_bank #(
  parameter int NUM_CH = 8,   // 1..65, bounded by the address window
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  parameter int SYNC_N = 2,
  localparam int CNT_W = DATA_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] ch_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ack_o,
  output logic              unk_o
);
  logic [NUM_CH-1:0]            lvl_all;
  logic [NUM_CH-1:0][CNT_W-1:0] cnt_all;

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      rate_chan #(.CNT_W(CNT_W), .SYNC_N(SYNC_N)) u_chan (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .in_i  (ch_i[g]),
        .lvl_o (lvl_all[g]),
        .cnt_o (cnt_all[g])
      );
    end
  endgenerate

  rate_rd #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (lvl_all),
    .cnt_i  (cnt_all),
    .addr_i (addr_i),
    .rd_i   (rd_i),
    .rdata_o(rdata_o),
    .ack_o  (ack_o),
    .unk_o  (unk_o)
  );
endmodule

// File: rtl/rate_bank_chk.sv
module rate_bank_chk
  import rate_bank_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  localparam int CNT_W = DATA_W - 1
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic [ADDR_W-1:0]            addr_i,
  input logic                         rd_i,
  input logic [DATA_W-1:0]            rdata_o,
  input logic                         ack_o,
  input logic                         unk_o,
  input logic [NUM_CH-1:0][CNT_W-1:0] cnt_all
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(RATE_BASE);
  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(RATE_LAST);

  logic [ADDR_W-1:0] off_s;
  logic              in_win_s;
  logic              reg_s;

  assign off_s    = addr_i - BASE_A;
  assign in_win_s = (addr_i >= BASE_A) && (addr_i <= LAST_A);
  assign reg_s    = in_win_s && (off_s < ADDR_W'(NUM_CH));

  AST_ACK_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && reg_s |=> ack_o && !unk_o); // R5

  AST_UNK_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && in_win_s && !reg_s |=> unk_o && !ack_o); // R6

  AST_UNK_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unk_o |-> rdata_o == '0); // R6

  AST_OUTSIDE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !in_win_s |=> !ack_o && !unk_o); // R7

  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> !ack_o && !unk_o); // R8

  AST_RESP_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_o && unk_o)); // R8

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_cnt
      AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(cnt_all[g]) |-> cnt_all[g] == CNT_W'($past(cnt_all[g]) + 1'b1)); // R2 R4
    end
  endgenerate
endmodule

bind rate_bank rate_bank_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .addr_i (addr_i),
  .rd_i   (rd_i),
  .rdata_o(rdata_o),
  .ack_o  (ack_o),
  .unk_o  (unk_o),
  .cnt_all(cnt_all)
);

// File: tb/rate_bank_test.sv
module rate_bank_test;
  localparam int NCH = 8;

  typedef struct {
    logic        ack;
    logic        unk;
    logic        coh;
    logic [31:0] data;
    logic [31:0] alt;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [NCH-1:0] ch = '0;
  logic [15:0] addr = '0;
  logic        rd = 1'b0;
  logic [31:0] rdata;
  logic        ack, unk;

  logic        w_in = 1'b0;
  logic [15:0] w_addr = '0;
  logic        w_rd = 1'b0;
  logic [3:0]  w_data;
  logic        w_ack, w_unk;

  int total = 0;
  int bad = 0;
  int model_cnt [NCH];
  logic rd_seen = 1'b0;
  logic done = 1'b0;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  rate_bank #(.NUM_CH(NCH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ch_i(ch), .addr_i(addr), .rd_i(rd),
    .rdata_o(rdata), .ack_o(ack), .unk_o(unk)
  );

  rate_bank #(.NUM_CH(1), .DATA_W(4)) uut_wrap (
    .clk_i(clk), .rst_ni(rst_n), .ch_i(w_in), .addr_i(w_addr), .rd_i(w_rd),
    .rdata_o(w_data), .ack_o(w_ack), .unk_o(w_unk)
  );

  always @(posedge clk) rd_seen <= rd;

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_seen) begin
        exp_t e;
        e = exp_q.pop_front();
        total++;
        if (ack !== e.ack || unk !== e.unk) begin
          bad++;
          $display("FAIL %s: ack/unk=%b%b expected %b%b", e.req, ack, unk, e.ack, e.unk);
        end else if ((e.ack || e.unk) && rdata !== e.data && !(e.coh && rdata === e.alt)) begin
          bad++;
          $display("FAIL %s: rdata=%h expected %h", e.req, rdata, e.data);
        end
      end else if (ack || unk) begin
        total++;
        bad++;
        $display("FAIL R8: unsolicited ack/unk=%b%b expected 00", ack, unk);
      end
    end
  end

  task automatic rd_push(input logic [15:0] a, input exp_t e);
    addr = a;
    rd = 1'b1;
    exp_q.push_back(e);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic rd_reg(input int c, input logic lvl, input string req);
    exp_t e;
    e.ack = 1'b1; e.unk = 1'b0; e.coh = 1'b0; e.req = req;
    e.data = {lvl, 31'(model_cnt[c])}; e.alt = '0;
    rd_push(16'hC000 + 16'(c), e);
  endtask

  task automatic rd_kind(input logic [15:0] a, input logic u, input string req);
    exp_t e;
    e.ack = 1'b0; e.unk = u; e.coh = 1'b0; e.req = req;
    e.data = '0; e.alt = '0;
    rd_push(a, e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input int c);
    ch[c] = 1'b1;
    idle(2);
    ch[c] = 1'b0;
    idle(2);
    model_cnt[c]++;
  endtask

  task automatic w_pulse();
    w_in = 1'b1;
    idle(2);
    w_in = 1'b0;
    idle(2);
  endtask

  task automatic w_check(input logic [3:0] exp, input string req);
    w_addr = 16'hC000;
    w_rd = 1'b1;
    @(negedge clk);
    w_rd = 1'b0;
    total++;
    if (!w_ack || w_data !== exp) begin
      bad++;
      $display("FAIL %s: ack=%b data=%h expected ack=1 data=%h", req, w_ack, w_data, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    total++;
    $display("FAIL watchdog: run did not finish, expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NCH; i++) model_cnt[i] = 0;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state of every register
    for (int i = 0; i < NCH; i++) rd_reg(i, 1'b0, "R1");

    // R2 counts, R9 isolation of untouched channels
    for (int i = 0; i < 3; i++) pulse(0);
    pulse(3);
    idle(4);
    rd_reg(0, 1'b0, "R2");
    rd_reg(3, 1'b0, "R2");
    rd_reg(1, 1'b0, "R9");
    rd_reg(7, 1'b0, "R9");

    // R3 live level, falling edge not counted (R2)
    ch[5] = 1'b1;
    model_cnt[5]++;
    idle(4);
    rd_reg(5, 1'b1, "R3");
    ch[5] = 1'b0;
    idle(4);
    rd_reg(5, 1'b0, "R2");

    // R5 top implemented address
    pulse(7);
    idle(4);
    rd_reg(7, 1'b0, "R5");

    // R6 gap inside window
    rd_kind(16'hC000 + 16'(NCH), 1'b1, "R6");
    rd_kind(16'hC040, 1'b1, "R6");
    // R7 outside window
    rd_kind(16'hBFFF, 1'b0, "R7");
    rd_kind(16'hC041, 1'b0, "R7");
    rd_kind(16'h0000, 1'b0, "R7");
    // R8 quiet bus
    idle(5);

    // R10 back-to-back reads across a rising edge
    begin
      int k;
      k = model_cnt[2];
      ch[2] = 1'b1;
      for (int i = 0; i < 6; i++) begin
        exp_t e;
        e.ack = 1'b1; e.unk = 1'b0; e.coh = 1'b1; e.req = "R10";
        e.data = {1'b0, 31'(k)};
        e.alt  = {1'b1, 31'(k + 1)};
        rd_push(16'hC002, e);
      end
      model_cnt[2]++;
      rd_reg(2, 1'b1, "R10");
      ch[2] = 1'b0;
      idle(4);
      rd_reg(2, 1'b0, "R10");
    end

    // R4 wrap on a 3-bit counter
    for (int i = 0; i < 7; i++) w_pulse();
    idle(2);
    w_check(4'h7, "R4");
    w_pulse();
    idle(2);
    w_check(4'h0, "R4");
    w_pulse();
    idle(2);
    w_check(4'h1, "R4");

    idle(3);
    if (exp_q.size() != 0) begin
      total++;
      bad++;
      $display("FAIL R8: %0d reads unanswered, expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule